// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit condition word of a small processor core. Each cycle it can take the result byte of the arithmetic unit and the unit's carry outputs and turn them into sign, zero, half-carry, parity, signed-overflow and signed-compare flags. It also holds a carry bit that a separate carry unit works out. Four independent update strobes let the instruction decoder choose which flags an operation changes. A second source for the compare flag records the carry out of a 16-bit incrementer/decrementer.

The same word can be restored from the shared tri-state data bus when flags are popped. It can also be placed on that bus when flags are pushed or a conditional branch is resolved. A zero-accumulate mode lets a two-byte operation leave the zero flag set only when every byte was zero. All updates are synchronous to the rising clock edge. An active-low synchronous reset clears the whole word.

Top module: `psw_flag_reg`

## Requirements
- R1: While reset is asserted at a rising edge, all eight flag bits are 0 after that edge.
- R2: With the arithmetic strobe high, the next edge loads bit 7 with result bit 7, bit 6 with 1 when the result is all zero, bit 4 with the carry out of result bit 3, and bit 2 with 1 when the result holds an even number of ones.
- R3: With the arithmetic strobe and zero-accumulate both high, bit 6 becomes the previous bit 6 AND (result equals zero).
- R4: With the carry strobe high, bit 0 takes the carry-unit input. The strobe touches no other bit.
- R5: With the overflow strobe high, bit 1 takes the carry into result bit 7 XOR the carry out of result bit 7.
- R6: With the compare strobe high, bit 5 takes the newly computed overflow XOR result bit 7. After a subtract this equals 1 exactly when the first operand is smaller as a signed value.
- R7: With the incrementer strobe high, bit 5 takes the 16-bit incrementer carry. This wins over the compare strobe in the same cycle.
- R8: Flags whose strobe is low keep their value. With every strobe and the bus load low, the word is unchanged.
- R9: With bus load high, the next edge writes all flags from the data bus, with bit 3 forced to 0. Bus load takes priority over every other strobe in that cycle, and bit 3 of the word is always 0.
- R10: With bus drive high, the data bus carries the flag word, with bit 3 actively driven 0. With bus drive low, the block leaves the bus at high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_result | input | 8 | Result byte from the arithmetic unit |
| alu_c3_out | input | 1 | Carry out of result bit 3 |
| alu_c7_in | input | 1 | Carry into result bit 7 |
| alu_c7_out | input | 1 | Carry out of result bit 7 |
| carry_next | input | 1 | Carry value chosen by the carry unit |
| incdec_carry | input | 1 | Carry out of the 16-bit incrementer/decrementer |
| upd_arith | input | 1 | Update sign, zero, half-carry and parity |
| zero_accum | input | 1 | Zero-accumulate mode for multi-byte results |
| upd_carry | input | 1 | Update carry |
| upd_ovf | input | 1 | Update signed overflow |
| upd_cmp | input | 1 | Update compare flag from overflow and sign |
| upd_incdec | input | 1 | Update compare flag from incrementer carry |
| bus_load | input | 1 | Load the whole word from the data bus |
| bus_drive | input | 1 | Drive the word onto the data bus |
| data_bus | inout | 8 | Shared tri-state data bus |
| flags_out | output | 8 | Current flag word for branch logic |

## Verification
On every cycle the assertions check the reset clear, that bit 3 is always zero, and that each strobe's bit is loaded from the inputs of the cycle before. They also check the load from the bus and the drive of the word while the block owns the bus. Only the bench scenarios show the exact value of whole words (including parity and the compare flag against a real subtract), the zero-accumulate chain across several bytes, and the priority of the incrementer source. They also show that the bus stays free when drive is low.

// File: rtl/psw_flag_pkg.sv
// Package: shared widths, bit positions and the flag word type.
// Assumes an eight-bit result and the fixed bit layout below.
package psw_flag_pkg;

    localparam int DATA_W   = 8;
    localparam int NIB_BIT  = 3;            // half-carry comes out of this bit
    localparam int SIGN_BIT = DATA_W - 1;

    // Bit order matches the bus layout: 7 sign .. 0 carry.
    typedef struct packed {
        logic sign;     // 7
        logic zero;     // 6
        logic cmp;      // 5
        logic half;     // 4
        logic fixed0;   // 3, always zero
        logic parity;   // 2
        logic ovf;      // 1
        logic carry;    // 0
    } flag_word_t;

    localparam logic [DATA_W-1:0] FIXED_MASK = 8'hF7;

endpackage

// File: rtl/psw_flag_calc.sv
// Module: combinational flag generation from an arithmetic result.
// Assumes the carries are supplied by the arithmetic unit; pure logic, no state.
module psw_flag_calc
    import psw_flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] result,
    input  logic         c_half,
    input  logic         c_top_in,
    input  logic         c_top_out,
    output logic         f_sign,
    output logic         f_zero,
    output logic         f_half,
    output logic         f_parity,
    output logic         f_ovf,
    output logic         f_cmp
);
    localparam int TOP = W - 1;

    // Derive each flag value from the current result.
    always_comb begin
        f_sign   = result[TOP];
        f_zero   = (result == '0);
        f_half   = c_half;
        f_parity = ~(^result);
        f_ovf    = c_top_in ^ c_top_out;
        f_cmp    = f_ovf ^ result[TOP];
    end

endmodule

// File: rtl/psw_flag_store.sv
// Module: flag storage with per-group update strobes and bus restore.
// Assumes bus load outranks all strobes; incrementer source outranks compare.
module psw_flag_store
    import psw_flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         f_sign,
    input  logic         f_zero,
    input  logic         f_half,
    input  logic         f_parity,
    input  logic         f_ovf,
    input  logic         f_cmp,
    input  logic         carry_next,
    input  logic         incdec_carry,
    input  logic         upd_arith,
    input  logic         zero_accum,
    input  logic         upd_carry,
    input  logic         upd_ovf,
    input  logic         upd_cmp,
    input  logic         upd_incdec,
    input  logic         bus_load,
    input  logic [W-1:0] bus_in,
    output flag_word_t   word_q
);
    flag_word_t word_d;
    flag_word_t bus_word;

    // Restored word from the bus with the fixed bit cleared.
    always_comb begin
        bus_word        = flag_word_t'(bus_in & FIXED_MASK);
        bus_word.fixed0 = 1'b0;
    end

    // Next-state selection for each flag group.
    always_comb begin
        word_d = word_q;
        if (bus_load) begin
            word_d = bus_word;
        end else begin
            if (upd_arith) begin
                word_d.sign   = f_sign;
                word_d.zero   = zero_accum ? (word_q.zero & f_zero) : f_zero;
                word_d.half   = f_half;
                word_d.parity = f_parity;
            end
            if (upd_carry) word_d.carry = carry_next;
            if (upd_ovf)   word_d.ovf   = f_ovf;
            if (upd_incdec)   word_d.cmp = incdec_carry;
            else if (upd_cmp) word_d.cmp = f_cmp;
        end
        word_d.fixed0 = 1'b0;
    end

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

endmodule

// File: rtl/psw_flag_bus.sv
// Module: tri-state bus port for the flag word.
// Assumes one driver at a time on the shared bus; bit 3 is driven low when enabled.
module psw_flag_bus
    import psw_flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         bus_drive,
    input  flag_word_t   word,
    output logic [W-1:0] bus_in,
    inout  wire  [W-1:0] data_bus
);
    logic [W-1:0] drive_val;

    // Value placed on the bus, fixed bit forced low.
    always_comb drive_val = W'(word) & FIXED_MASK;

    assign data_bus = bus_drive ? drive_val : {W{1'bz}};
    assign bus_in   = data_bus;

endmodule

// File: rtl/psw_flag_reg.sv
// Module: processor status flag register top.
// Assumes strobes come from an instruction decoder and are valid at the rising edge.
module psw_flag_reg
    import psw_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_c3_out,
    input  logic              alu_c7_in,
    input  logic              alu_c7_out,
    input  logic              carry_next,
    input  logic              incdec_carry,
    input  logic              upd_arith,
    input  logic              zero_accum,
    input  logic              upd_carry,
    input  logic              upd_ovf,
    input  logic              upd_cmp,
    input  logic              upd_incdec,
    input  logic              bus_load,
    input  logic              bus_drive,
    inout  wire  [DATA_W-1:0] data_bus,
    output logic [DATA_W-1:0] flags_out
);
    logic f_sign, f_zero, f_half, f_parity, f_ovf, f_cmp;
    logic [DATA_W-1:0] bus_in;
    flag_word_t word_q;

    psw_flag_calc #(.W(DATA_W)) u_calc (
        .result    (alu_result),
        .c_half    (alu_c3_out),
        .c_top_in  (alu_c7_in),
        .c_top_out (alu_c7_out),
        .f_sign    (f_sign),
        .f_zero    (f_zero),
        .f_half    (f_half),
        .f_parity  (f_parity),
        .f_ovf     (f_ovf),
        .f_cmp     (f_cmp)
    );

    psw_flag_store #(.W(DATA_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .f_sign       (f_sign),
        .f_zero       (f_zero),
        .f_half       (f_half),
        .f_parity     (f_parity),
        .f_ovf        (f_ovf),
        .f_cmp        (f_cmp),
        .carry_next   (carry_next),
        .incdec_carry (incdec_carry),
        .upd_arith    (upd_arith),
        .zero_accum   (zero_accum),
        .upd_carry    (upd_carry),
        .upd_ovf      (upd_ovf),
        .upd_cmp      (upd_cmp),
        .upd_incdec   (upd_incdec),
        .bus_load     (bus_load),
        .bus_in       (bus_in),
        .word_q       (word_q)
    );

    psw_flag_bus #(.W(DATA_W)) u_bus (
        .bus_drive (bus_drive),
        .word      (word_q),
        .bus_in    (bus_in),
        .data_bus  (data_bus)
    );

    // Flag word for branch-condition logic.
    always_comb flags_out = DATA_W'(word_q);

endmodule

// File: rtl/psw_flag_reg_chk.sv
// Module: assertion checker bound to the flag register top.
// Assumes it sees only the top-level ports.
module psw_flag_reg_chk
    import psw_flag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] alu_result,
    input logic              alu_c7_in,
    input logic              alu_c7_out,
    input logic              carry_next,
    input logic              incdec_carry,
    input logic              upd_arith,
    input logic              zero_accum,
    input logic              upd_carry,
    input logic              upd_ovf,
    input logic              upd_cmp,
    input logic              upd_incdec,
    input logic              bus_load,
    input logic              bus_drive,
    input logic [DATA_W-1:0] data_bus,
    input logic [DATA_W-1:0] flags_out
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> flags_out == '0);

    p_sign_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_arith && !bus_load) |=> flags_out[7] == $past(alu_result[7]));

    p_zero_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_arith && zero_accum && !bus_load) |=>
        flags_out[6] == ($past(flags_out[6]) && ($past(alu_result) == '0)));

    p_carry_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_carry && !bus_load) |=> flags_out[0] == $past(carry_next));

    p_ovf_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ovf && !bus_load) |=> flags_out[1] == ($past(alu_c7_in) ^ $past(alu_c7_out)));

    p_cmp_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_cmp && !upd_incdec && !bus_load) |=>
        flags_out[5] == ($past(alu_c7_in) ^ $past(alu_c7_out) ^ $past(alu_result[7])));

    p_incdec_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_incdec && !bus_load) |=> flags_out[5] == $past(incdec_carry));

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_arith && !upd_carry && !upd_ovf && !upd_cmp && !upd_incdec && !bus_load)
        |=> $stable(flags_out));

    p_bus_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_load |=> flags_out == ($past(data_bus) & 8'hF7));

    p_fixed_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[3] == 1'b0);

    p_bus_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> data_bus == flags_out);

endmodule

bind psw_flag_reg psw_flag_reg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alu_result   (alu_result),
    .alu_c7_in    (alu_c7_in),
    .alu_c7_out   (alu_c7_out),
    .carry_next   (carry_next),
    .incdec_carry (incdec_carry),
    .upd_arith    (upd_arith),
    .zero_accum   (zero_accum),
    .upd_carry    (upd_carry),
    .upd_ovf      (upd_ovf),
    .upd_cmp      (upd_cmp),
    .upd_incdec   (upd_incdec),
    .bus_load     (bus_load),
    .bus_drive    (bus_drive),
    .data_bus     (data_bus),
    .flags_out    (flags_out)
);

// File: tb/psw_flag_reg_tb_top.sv
// Bench: vector table for full updates, then directed cases.
module psw_flag_reg_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] alu_result = '0;
    logic alu_c3_out = 0, alu_c7_in = 0, alu_c7_out = 0;
    logic carry_next = 0, incdec_carry = 0;
    logic upd_arith = 0, zero_accum = 0, upd_carry = 0, upd_ovf = 0;
    logic upd_cmp = 0, upd_incdec = 0, bus_load = 0, bus_drive = 0;
    logic tb_bus_en = 0;
    logic [7:0] tb_bus_val = '0;
    wire  [7:0] data_bus;
    logic [7:0] flags_out;

    int checks = 0;
    int errors = 0;

    assign data_bus = tb_bus_en ? tb_bus_val : 8'bz;

    always #10 clk = ~clk;   // 50 MHz

    psw_flag_reg dut_i (
        .clk(clk), .rst_n(rst_n), .alu_result(alu_result),
        .alu_c3_out(alu_c3_out), .alu_c7_in(alu_c7_in), .alu_c7_out(alu_c7_out),
        .carry_next(carry_next), .incdec_carry(incdec_carry),
        .upd_arith(upd_arith), .zero_accum(zero_accum), .upd_carry(upd_carry),
        .upd_ovf(upd_ovf), .upd_cmp(upd_cmp), .upd_incdec(upd_incdec),
        .bus_load(bus_load), .bus_drive(bus_drive), .data_bus(data_bus),
        .flags_out(flags_out)
    );

    // {result, c3, c7in, c7out, carry, pad, expected word}; all strobes high.
    localparam logic [23:0] VEC [6] = '{
        24'h00_0_0_44,
        24'h80_4_0_82,
        24'h7F_B_0_33,
        24'h03_F_0_15,
        24'hF0_0_0_A4,
        24'h01_5_0_23
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        upd_arith = 0; zero_accum = 0; upd_carry = 0; upd_ovf = 0;
        upd_cmp = 0; upd_incdec = 0; bus_load = 0; bus_drive = 0; tb_bus_en = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic alu(input logic [7:0] r, input logic c3, input logic ci, input logic co);
        alu_result = r; alu_c3_out = c3; alu_c7_in = ci; alu_c7_out = co;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        check("R1 reset clear", flags_out, 8'h00);
        rst_n = 1;

        // R2 R4 R5 R6 full-update table
        foreach (VEC[i]) begin
            idle();
            alu(VEC[i][23:16], VEC[i][15], VEC[i][14], VEC[i][13]);
            carry_next = VEC[i][12];
            upd_arith = 1; upd_carry = 1; upd_ovf = 1; upd_cmp = 1;
            step();
            check("R2 R4 R5 R6 vector", flags_out, VEC[i][7:0]);
        end
        idle();

        // R8: no strobes, inputs change, word holds (0x23 from last vector)
        alu(8'h00, 1, 1, 0); carry_next = 0; incdec_carry = 1;
        step();
        check("R8 hold", flags_out, 8'h23);

        // R4: carry strobe alone touches only bit 0
        carry_next = 0; upd_carry = 1;
        step();
        check("R4 carry only", flags_out, 8'h22);
        idle();

        // R5: overflow strobe alone, c7in=0 c7out=0 -> bit1 cleared
        alu(8'hFF, 1, 0, 0); upd_ovf = 1;
        step();
        check("R5 ovf only", flags_out, 8'h20);
        idle();

        // R6: 5 - 7 = FE, no carry into or out of bit 7 -> K=1 (5 < 7 signed)
        alu(8'h00, 0, 0, 0); upd_cmp = 1;
        step();
        check("R6 cmp clear", flags_out, 8'h00);
        alu(8'hFE, 0, 0, 0);
        step();
        check("R6 signed less", flags_out, 8'h20);
        idle();

        // R7: incrementer carry wins over compare (compare would give 0)
        alu(8'h00, 0, 0, 0); upd_cmp = 1; upd_incdec = 1; incdec_carry = 0;
        step();
        check("R7 incdec clear", flags_out, 8'h00);
        alu(8'h00, 0, 0, 0); incdec_carry = 1;
        step();
        check("R7 incdec priority", flags_out, 8'h20);
        idle();

        // R3: zero-accumulate chain
        alu(8'h00, 0, 0, 0); upd_arith = 1;
        step();                                     // Z=1, P=1, K held
        check("R2 zero byte", flags_out, 8'h64);
        zero_accum = 1;
        step();
        check("R3 chain zero stays", flags_out, 8'h64);
        zero_accum = 0; alu(8'h05, 0, 0, 0);
        step();                                     // Z=0, P=1
        check("R2 nonzero byte", flags_out, 8'h24);
        zero_accum = 1; alu(8'h00, 0, 0, 0);
        step();
        check("R3 chain zero blocked", flags_out, 8'h24);
        idle();

        // R9: bus load with bit 3 forced 0 and priority over arithmetic
        tb_bus_en = 1; tb_bus_val = 8'hFF; bus_load = 1;
        upd_arith = 1; upd_carry = 1; carry_next = 0; alu(8'h00, 0, 0, 0);
        step();
        check("R9 bus load priority", flags_out, 8'hF7);
        idle();

        // R10: drive word onto bus, bit 3 low
        bus_drive = 1;
        #1;
        check("R10 bus drive", data_bus, 8'hF7);
        idle();

        // R10: released bus carries the bench value unchanged
        tb_bus_en = 1; tb_bus_val = 8'h08;
        #1;
        check("R10 bus released", data_bus, 8'h08);
        idle();

        // R9: restore a sparse word, then R1 reset again
        tb_bus_en = 1; tb_bus_val = 8'h5A; bus_load = 1;
        step();
        check("R9 bus restore", flags_out, 8'h52);
        idle();
        rst_n = 0;
        step();
        check("R1 reset again", flags_out, 8'h00);
        rst_n = 1;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule